// File: doc/BRIEF.md
# Signed Register-Pair Multiply Unit

This unit performs a signed 32 by 32 bit multiplication for a processor whose general registers can be paired as an even/odd couple. When an operation starts, the unit names the register that holds the multiplicand. That register is the requested index with its least significant bit forced to one. The unit captures the multiplicand, the 32-bit effective operand and the register index. It then forms the 64-bit two's complement product with a radix-2 shift-add loop that handles one multiplier bit per clock.

When the loop finishes, the unit raises a single-cycle completion strobe. In that same cycle it drives two register write ports and a set of condition-code flags, each flag with its own update enable. An even index receives the upper product word and its odd partner receives the lower word. An odd index receives only the lower word.

The flags always describe the whole 64-bit product and never the word that was written back. One flag reports whether the lower word alone can hold the product. The operation cannot overflow, so the unit has no overflow or trap output.

Top module: `pm_pair_mul`

## Requirements
- R1: `src_idx` always equals `reg_idx` with bit 0 forced to 1. It names the register whose contents the caller presents on `mcand`.
- R2: For an even captured index R, in the `done` cycle port 0 writes the upper 32 product bits to index R and port 1 writes the lower 32 bits to index R+1. Both enables are high.
- R3: For an odd captured index R, in the `done` cycle port 0 writes the lower 32 product bits to index R and `wb1_en` stays low.
- R4: The product is the exact signed two's complement product of `mcand` and `mplier`, both 32-bit signed values, for every operand including 0, -1, 0x80000000 and 0x7FFFFFFF.
- R5: In the `done` cycle, `cc_val[1]` (positive) is 1 exactly when the 64-bit product is greater than zero, and `cc_val[0]` (negative) is 1 exactly when it is less than zero. A zero product gives both as 0.
- R6: In the `done` cycle, `cc_val[2]` (wide) is 1 exactly when the 64-bit product differs from the sign extension of its lower 32 bits.
- R7: `cc_upd` is 4'b0111 in the `done` cycle and 4'b0000 in every other cycle. Bit 3 (the first flag) is never updated, and `cc_val[3]` is 0.
- R8: `done` is high for exactly one cycle, 32 clock edges after the edge that accepts `start`. `busy` is high from the accepting edge until that edge.
- R9: A `start` seen while `busy` is high is ignored and does not shift the completion time. Changes to `reg_idx`, `mcand` or `mplier` after acceptance do not alter the result.
- R10: While reset is held and after it is released, `busy`, `done`, both write enables and `cc_upd` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request to begin a multiply, accepted when not busy |
| reg_idx | input | 4 | Destination register index R |
| mcand | input | 32 | Multiplicand, the contents of register `src_idx` |
| mplier | input | 32 | Effective operand used as the multiplier |
| src_idx | output | 4 | Register index to read for the multiplicand |
| busy | output | 1 | Multiply in progress |
| done | output | 1 | One-cycle completion strobe |
| wb0_en | output | 1 | Write enable, port 0 |
| wb0_idx | output | 4 | Register index, port 0 |
| wb0_data | output | 32 | Write data, port 0 |
| wb1_en | output | 1 | Write enable, port 1 |
| wb1_idx | output | 4 | Register index, port 1 |
| wb1_data | output | 32 | Write data, port 1 |
| cc_val | output | 4 | Flag values: [3] first, [2] wide, [1] positive, [0] negative |
| cc_upd | output | 4 | Per-flag update enables, same bit order as `cc_val` |

## Verification
The bench drives 0x80000000 times itself, -1 times 0x80000000 and 0x7FFFFFFF squared. A loop that treats the top multiplier bit as positive, or that loses the carry into bit 63, returns a wrong upper word or a wrong sign flag for these operands. Products such as -1 times 1 and 0x80000000 times 1 fit exactly in the lower word and must clear the wide flag. A check that tested only whether the upper word is zero would wrongly set the flag for these small negative products. Odd destination indices are mixed with even ones, so that a design writing the wrong half or still enabling the second port gets caught. Operands and index are scrambled, and a second start is issued, while a multiply is running. A design that does not latch its inputs, or that restarts its loop, returns corrupted data or completes late.

// File: rtl/pm_pkg.sv
package pm_pkg;

    localparam int unsigned XLEN  = 32;
    localparam int unsigned RIDX_W = 4;

    // Flag order, most significant first: first, wide, positive, negative.
    typedef struct packed {
        logic first;
        logic wide;
        logic pos;
        logic neg;
    } ccf_t;

    localparam ccf_t CC_NONE    = '{first: 1'b0, wide: 1'b0, pos: 1'b0, neg: 1'b0};
    localparam ccf_t CC_UPD_MUL = '{first: 1'b0, wide: 1'b1, pos: 1'b1, neg: 1'b1};

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_RUN  = 2'b01,
        ST_DONE = 2'b10
    } pm_state_e;

    function automatic ccf_t cc_build(input logic is_neg, input logic is_zero,
                                      input logic is_wide);
        ccf_t f;
        f.first = 1'b0;
        f.wide  = is_wide;
        f.neg   = is_neg;
        f.pos   = !is_neg && !is_zero;
        return f;
    endfunction

endpackage

// File: rtl/pm_ctrl.sv
module pm_ctrl
    import pm_pkg::*;
#(
    parameter int unsigned W      = 32,
    parameter int unsigned IDX_W  = 4,
    localparam int unsigned CNT_W = $clog2(W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] reg_idx,
    output logic             load,
    output logic             step,
    output logic             last,
    output logic             busy,
    output logic             done,
    output logic [IDX_W-1:0] idx_q
);

    pm_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic             accept;

    assign accept = start && (state != ST_RUN);
    assign busy   = (state == ST_RUN);
    assign done   = (state == ST_DONE);
    assign load   = accept;
    assign step   = busy;
    assign last   = busy && (cnt == CNT_W'(W - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            idx_q <= '0;
        end else begin
            unique case (state)
                ST_RUN: begin
                    cnt <= cnt + CNT_W'(1);
                    if (cnt == CNT_W'(W - 1)) begin
                        state <= ST_DONE;
                    end
                end
                default: begin
                    if (accept) begin
                        state <= ST_RUN;
                        cnt   <= '0;
                        idx_q <= reg_idx;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // R8: completion is a single-cycle strobe
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8: the busy window ends only into a completion
    a_r8_busy_to_done: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R9: a request during a run does not disturb the captured index or restart the count
    a_r9_ignore_start: assert property (@(posedge clk) disable iff (rst)
        (busy && !last) |=> ($stable(idx_q) && busy && cnt == $past(cnt) + CNT_W'(1)));

endmodule

// File: rtl/pm_datapath.sv
module pm_datapath #(
    parameter int unsigned W   = 32,
    localparam int unsigned PW = 2 * W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic                step,
    input  logic                last,
    input  logic signed [W-1:0] mcand,
    input  logic signed [W-1:0] mplier,
    output logic signed [PW-1:0] prod
);

    logic signed [PW-1:0] a_sh;
    logic        [W-1:0]  b_sh;
    logic signed [PW-1:0] acc;
    logic signed [PW-1:0] term;
    logic signed [PW-1:0] acc_nx;

    // The top multiplier bit carries negative weight in two's complement.
    assign term   = b_sh[0] ? a_sh : '0;
    assign acc_nx = last ? (acc - term) : (acc + term);
    assign prod   = acc;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_sh <= '0;
            b_sh <= '0;
            acc  <= '0;
        end else if (load) begin
            a_sh <= PW'(mcand);
            b_sh <= mplier;
            acc  <= '0;
        end else if (step) begin
            acc  <= acc_nx;
            a_sh <= a_sh <<< 1;
            b_sh <= b_sh >> 1;
        end
    end

    // R4: a zero multiplier bit leaves the partial product untouched
    a_r4_zero_bit_hold: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !b_sh[0]) |=> (acc == $past(acc)));

endmodule

// File: rtl/pm_writeback.sv
module pm_writeback
    import pm_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = 4,
    localparam int unsigned PW   = 2 * W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 done,
    input  logic [IDX_W-1:0]     idx_q,
    input  logic signed [PW-1:0] prod,
    output logic                 wb0_en,
    output logic [IDX_W-1:0]     wb0_idx,
    output logic [W-1:0]         wb0_data,
    output logic                 wb1_en,
    output logic [IDX_W-1:0]     wb1_idx,
    output logic [W-1:0]         wb1_data,
    output ccf_t                 cc_val,
    output ccf_t                 cc_upd
);

    logic [W-1:0]  hi_w;
    logic [W-1:0]  lo_w;
    logic          odd_dst;
    logic          p_zero;
    logic          p_neg;
    logic          p_wide;
    ccf_t          flags;

    assign hi_w    = prod[PW-1:W];
    assign lo_w    = prod[W-1:0];
    assign odd_dst = idx_q[0];

    assign p_zero  = (prod == '0);
    assign p_neg   = prod[PW-1];
    assign p_wide  = (hi_w != {W{lo_w[W-1]}});
    assign flags   = cc_build(p_neg, p_zero, p_wide);

    assign wb0_en   = done;
    assign wb0_idx  = idx_q;
    assign wb0_data = odd_dst ? lo_w : hi_w;

    assign wb1_en   = done && !odd_dst;
    assign wb1_idx  = idx_q | IDX_W'(1);
    assign wb1_data = lo_w;

    assign cc_val   = done ? flags : CC_NONE;
    assign cc_upd   = done ? CC_UPD_MUL : CC_NONE;

    // R3: an odd destination never opens the second port
    a_r3_odd_single: assert property (@(posedge clk) disable iff (rst)
        (wb0_en && wb0_idx[0]) |-> !wb1_en);

    // R2: the second port always targets the partner of the first
    a_r2_pair_index: assert property (@(posedge clk) disable iff (rst)
        wb1_en |-> (wb1_idx == wb0_idx + IDX_W'(1)) && wb0_en);

    // R5: positive and negative are exclusive
    a_r5_sign_excl: assert property (@(posedge clk) disable iff (rst)
        done |-> !(cc_val.pos && cc_val.neg));

    // R7: flag updates only accompany a write-back
    a_r7_upd_with_done: assert property (@(posedge clk) disable iff (rst)
        (cc_upd != CC_NONE) |-> wb0_en);

    // R6: a narrow product with a negative flag has a negative lower word
    a_r6_narrow_sign: assert property (@(posedge clk) disable iff (rst)
        (done && !cc_val.wide && cc_val.neg) |-> lo_w[W-1]);

endmodule

// File: rtl/pm_pair_mul.sv
module pm_pair_mul
    import pm_pkg::*;
#(
    parameter int unsigned W     = 32,
    parameter int unsigned IDX_W = 4,
    localparam int unsigned PW   = 2 * W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] reg_idx,
    input  logic [W-1:0]     mcand,
    input  logic [W-1:0]     mplier,
    output logic [IDX_W-1:0] src_idx,
    output logic             busy,
    output logic             done,
    output logic             wb0_en,
    output logic [IDX_W-1:0] wb0_idx,
    output logic [W-1:0]     wb0_data,
    output logic             wb1_en,
    output logic [IDX_W-1:0] wb1_idx,
    output logic [W-1:0]     wb1_data,
    output logic [3:0]       cc_val,
    output logic [3:0]       cc_upd
);

    logic             load;
    logic             step;
    logic             last;
    logic [IDX_W-1:0] idx_q;
    logic signed [PW-1:0] prod;
    ccf_t             ccv;
    ccf_t             ccu;

    assign src_idx = reg_idx | IDX_W'(1);
    assign cc_val  = ccv;
    assign cc_upd  = ccu;

    pm_ctrl #(.W(W), .IDX_W(IDX_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .reg_idx (reg_idx),
        .load    (load),
        .step    (step),
        .last    (last),
        .busy    (busy),
        .done    (done),
        .idx_q   (idx_q)
    );

    pm_datapath #(.W(W)) u_dp (
        .clk    (clk),
        .rst    (rst),
        .load   (load),
        .step   (step),
        .last   (last),
        .mcand  (mcand),
        .mplier (mplier),
        .prod   (prod)
    );

    pm_writeback #(.W(W), .IDX_W(IDX_W)) u_wb (
        .clk      (clk),
        .rst      (rst),
        .done     (done),
        .idx_q    (idx_q),
        .prod     (prod),
        .wb0_en   (wb0_en),
        .wb0_idx  (wb0_idx),
        .wb0_data (wb0_data),
        .wb1_en   (wb1_en),
        .wb1_idx  (wb1_idx),
        .wb1_data (wb1_data),
        .cc_val   (ccv),
        .cc_upd   (ccu)
    );

    // R10: nothing is written while idle after reset
    a_r10_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        (!done) |-> (!wb0_en && !wb1_en && cc_upd == 4'b0000));

endmodule

// File: tb/pm_pair_mul_tb.sv
module pm_pair_mul_tb;

    localparam int W     = 32;
    localparam int IDX_W = 4;

    typedef struct {
        logic [IDX_W-1:0] r;
        logic [W-1:0]     a;
        logic [W-1:0]     b;
        int               c0;
    } item_t;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [IDX_W-1:0] reg_idx = '0;
    logic [W-1:0]     mcand = '0;
    logic [W-1:0]     mplier = '0;
    logic [IDX_W-1:0] src_idx;
    logic             busy, done;
    logic             wb0_en, wb1_en;
    logic [IDX_W-1:0] wb0_idx, wb1_idx;
    logic [W-1:0]     wb0_data, wb1_data;
    logic [3:0]       cc_val, cc_upd;

    int    n_chk = 0;
    int    n_bad = 0;
    int    cyc   = 0;
    bit    finished = 0;
    item_t sb_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    pm_pair_mul #(.W(W), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .reg_idx(reg_idx),
        .mcand(mcand), .mplier(mplier), .src_idx(src_idx),
        .busy(busy), .done(done),
        .wb0_en(wb0_en), .wb0_idx(wb0_idx), .wb0_data(wb0_data),
        .wb1_en(wb1_en), .wb1_idx(wb1_idx), .wb1_data(wb1_data),
        .cc_val(cc_val), .cc_upd(cc_upd)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: issue one operation, optionally disturbing inputs while it runs.
    task automatic issue(input logic [IDX_W-1:0] r, input logic [W-1:0] a,
                         input logic [W-1:0] b, input bit disturb);
        item_t it;
        @(negedge clk);
        while (busy) @(negedge clk);
        reg_idx = r; mcand = a; mplier = b; start = 1'b1;
        #0.1;
        check(src_idx == (r | 4'd1), "R1 source index", 64'(src_idx), 64'(r | 4'd1));
        it.r = r; it.a = a; it.b = b; it.c0 = cyc;
        sb_q.push_back(it);
        @(negedge clk);
        start = 1'b0;
        reg_idx = $urandom; mcand = $urandom; mplier = $urandom;
        if (disturb) begin
            repeat (5) @(negedge clk);
            reg_idx = ~r; mcand = ~a; mplier = 32'h1234_5678; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            check(busy == 1'b1, "R9 busy during ignored start", 64'(busy), 64'd1);
        end
    endtask

    // Monitor: pop and compare on every completion.
    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (sb_q.size() == 0) begin
                    check(1'b0, "R9 unexpected completion", 64'd1, 64'd0);
                end else begin
                    item_t it;
                    logic signed [63:0] p;
                    logic [3:0] ecc;
                    it = sb_q.pop_front();
                    p = $signed(it.a) * $signed(it.b);
                    ecc = {1'b0, (p != {{32{p[31]}}, p[31:0]}), (p > 0), (p < 0)};
                    check(cyc - it.c0 == 33, "R8 latency", 64'(cyc - it.c0), 64'd33);
                    check(wb0_en && wb0_idx == it.r, "R2/R3 port0 target",
                          {wb0_en, 59'(wb0_idx)}, {1'b1, 59'(it.r)});
                    if (!it.r[0]) begin
                        check(wb0_data == p[63:32], "R2 R4 high word", 64'(wb0_data), 64'(p[63:32]));
                        check(wb1_en && wb1_idx == it.r + 4'd1, "R2 port1 target",
                              {wb1_en, 59'(wb1_idx)}, {1'b1, 59'(it.r + 4'd1)});
                        check(wb1_data == p[31:0], "R2 R4 low word", 64'(wb1_data), 64'(p[31:0]));
                    end else begin
                        check(wb0_data == p[31:0], "R3 R4 low word", 64'(wb0_data), 64'(p[31:0]));
                        check(!wb1_en, "R3 port1 idle", 64'(wb1_en), 64'd0);
                    end
                    check(cc_val[1:0] == ecc[1:0], "R5 sign flags", 64'(cc_val), 64'(ecc));
                    check(cc_val[2] == ecc[2], "R6 wide flag", 64'(cc_val), 64'(ecc));
                    check(cc_upd == 4'b0111 && !cc_val[3], "R7 update mask",
                          64'({cc_val[3], cc_upd}), 64'({1'b0, 4'b0111}));
                end
            end else begin
                if (cc_upd != 4'b0000 || wb0_en || wb1_en) begin
                    check(1'b0, "R7 update outside completion", 64'(cc_upd), 64'd0);
                end
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!busy && !done && !wb0_en && !wb1_en && cc_upd == 0, "R10 in reset",
              64'({busy, done, wb0_en, wb1_en, cc_upd}), 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !wb0_en && !wb1_en && cc_upd == 0, "R10 after reset",
              64'({busy, done, wb0_en, wb1_en, cc_upd}), 64'd0);

        // R4 corners, both parities
        issue(4'd2, 32'h8000_0000, 32'h8000_0000, 0);
        issue(4'd5, 32'h8000_0000, 32'h8000_0000, 0);
        issue(4'd4, 32'hFFFF_FFFF, 32'h8000_0000, 0);
        issue(4'd6, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 0);
        issue(4'd8, 32'h0000_0000, 32'h8000_0000, 0);
        issue(4'd3, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0);
        issue(4'd0, 32'hFFFF_FFFF, 32'h0000_0001, 0);   // R6 narrow negative
        issue(4'd10, 32'h8000_0000, 32'h0000_0001, 0);  // R6 narrow at limit
        issue(4'd12, 32'h7FFF_FFFF, 32'h8000_0000, 0);
        issue(4'd9, 32'h0001_0000, 32'h0000_8000, 0);   // R6 just wide
        issue(4'd14, 32'h0000_0007, 32'hFFFF_FFFD, 1);  // R9 disturbance
        issue(4'd7, 32'h8000_0000, 32'h7FFF_FFFF, 1);

        for (int i = 0; i < 40; i++) begin
            issue(4'($urandom), $urandom, $urandom, (i % 7) == 0);
        end

        @(negedge clk);
        while (busy || sb_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
        finished = 1;
        $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule